// File: doc/BRIEF.md
# Indirect Register Access Port

This block gives a byte-wide host a path into a bank of internal configuration registers through a single control address. The host does not present a register address on separate lines. It sends a pointer byte to the control address first, and the next access to that same address reaches the register the pointer names. A two-phase sequencer tracks whether the next access is a pointer or data access, so every data access is preceded by exactly one pointer write.

Register 0 is the master-control register, and its bit 0 is a unit reset bit. While that bit is set the unit is held in reset. All other registers are forced to zero, reads return zero, and any host write lands on the reset bit alone. A short fixed host sequence (read, write 0, read, write 0, write 1, write 0) brings the unit back to a clean idle state whatever phase it was left in. The pointer spans 64 byte addresses, and only the lowest `NUM_REGS` of them hold storage. The full register contents are presented on a flat image bus for the neighbouring logic that uses them.

Top module: `ira_port`

## Requirements
- R1: After the `rst_n` reset, `unit_in_reset` is 1, `data_phase` is 0, `host_rdata` is 0, and `reg_image` holds 0x01 in register 0 (byte 0 of the bus) and zero in every other register.
- R2: Out of reset, a host write in the pointer phase (`data_phase` = 0) loads the pointer from the low 6 bits of `host_wdata`, sets `data_phase` to 1 and changes no register.
- R3: A host write in the data phase stores `host_wdata` into the register the pointer names and returns `data_phase` to 0.
- R4: A host read in the data phase places the selected register's value on `host_rdata` after the next clock edge, returns `data_phase` to 0 and changes no register.
- R5: Out of reset, a host read in the pointer phase gives `host_rdata` = 0, leaves `data_phase` at 0 and changes no register.
- R6: A pointer at or above `NUM_REGS` reads as 0, and a data write through it changes no register.
- R7: Writing a byte with bit 0 set to register 0 enters reset: `unit_in_reset` becomes 1, register 0 holds exactly 0x01, all other registers become 0 and `data_phase` is 0.
- R8: While in reset, every host write goes to the reset bit alone and leaves `data_phase` at 0. Bit 0 of `host_wdata` = 1 keeps the unit in reset. Bit 0 = 0 releases it and leaves register 0 at 0x00. Other data bits are not stored.
- R9: While in reset, a host read returns 0, leaves `data_phase` at 0 and changes no register.
- R10: The host sequence read, write 0x00, read, write 0x00, write 0x01, write 0x00 ends with `data_phase` = 0, `unit_in_reset` = 0 and all registers zero. This holds from the pointer phase, from the data phase and from reset.
- R11: A cycle with `host_wr` and `host_rd` both high acts as a write only, and `host_rdata` keeps its value.
- R12: `host_rdata` changes only on a cycle with a read strobe and no write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe to the control address, one cycle per access |
| host_rd | input | 1 | Read strobe from the control address, one cycle per access |
| host_wdata | input | DATA_W | Write data: pointer or register byte |
| host_rdata | output | DATA_W | Registered read data, updated after a read strobe |
| unit_in_reset | output | 1 | Reset bit of the master-control register |
| data_phase | output | 1 | 1 when the next access is a data access |
| reg_image | output | NUM_REGS*DATA_W | All register contents, register i in bits [i*DATA_W +: DATA_W] |

## Verification
Directed sequences first cover each phase transition on its own. These are a pointer write whose upper data bits are non-zero, which shows the pointer truncation, and a data write and a data read-back. Further cases are a read in the pointer phase, a pointer beyond the implemented range, and simultaneous strobes. Register 0 is written with the reset bit set and its upper bits set, which shows that only the reset bit survives. The writes made in reset carry odd and even data and separate holding from releasing. The recovery sequence is started from each of the three possible states. A seeded random mix of reads, writes and reset-entering writes is then compared op by op with a bench model of the phase, pointer and register bank, which catches wrong phase ordering or mis-addressed writes over long runs.

// File: rtl/ira_pkg.sv
package ira_pkg;
   typedef enum logic {
      PH_PTR  = 1'b0,
      PH_DATA = 1'b1
   } ira_phase_e;
endpackage

// File: rtl/ira_seq.sv
module ira_seq
   import ira_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              in_reset,
   output ira_phase_e        phase_o,
   output logic [ADDR_W-1:0] ptr_o,
   output logic              we_o,
   output logic [ADDR_W-1:0] waddr_o,
   output logic              rsel_o
);

   ira_phase_e        phase_q;
   logic [ADDR_W-1:0] ptr_q;

   always_comb begin
      we_o    = wr && (in_reset || phase_q == PH_DATA);
      waddr_o = in_reset ? '0 : ptr_q;
      rsel_o  = rd && !wr && !in_reset && phase_q == PH_DATA;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_PTR;
         ptr_q   <= '0;
      end else if (in_reset) begin
         phase_q <= PH_PTR;
         ptr_q   <= '0;
      end else if (wr) begin
         if (phase_q == PH_PTR) begin
            ptr_q   <= wdata[ADDR_W-1:0];
            phase_q <= PH_DATA;
         end else begin
            phase_q <= PH_PTR;
         end
      end else if (rd) begin
         phase_q <= PH_PTR;
      end
   end

   assign phase_o = phase_q;
   assign ptr_o   = ptr_q;

endmodule

// File: rtl/ira_regfile.sv
module ira_regfile #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 6,
   parameter int NUM_REGS = 16,
   parameter int RST_BIT  = 0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [ADDR_W-1:0]          waddr,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [ADDR_W-1:0]          raddr,
   output logic [DATA_W-1:0]          rdata,
   output logic                       in_reset,
   output logic [NUM_REGS*DATA_W-1:0] image
);

   localparam logic [DATA_W-1:0] RST_ONE = {{(DATA_W-1){1'b0}}, 1'b1} << RST_BIT;

   logic enter_rst;
   assign in_reset  = image[RST_BIT];
   assign enter_rst = we && !in_reset && waddr == '0 && wdata[RST_BIT];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [DATA_W-1:0] q;
      if (i == 0) begin : g_ctrl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= RST_ONE;
            else if (we && waddr == '0) begin
               if (in_reset || wdata[RST_BIT])
                  q <= wdata[RST_BIT] ? RST_ONE : '0;
               else
                  q <= wdata;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (in_reset || enter_rst)
               q <= '0;
            else if (we && waddr == ADDR_W'(i))
               q <= wdata;
         end
      end
      assign image[i*DATA_W +: DATA_W] = q;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (raddr == ADDR_W'(i))
            rdata = image[i*DATA_W +: DATA_W];
   end

endmodule

// File: rtl/ira_port.sv
module ira_port
   import ira_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 6,
   parameter int NUM_REGS = 16,
   parameter int RST_BIT  = 0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       host_wr,
   input  logic                       host_rd,
   input  logic [DATA_W-1:0]          host_wdata,
   output logic [DATA_W-1:0]          host_rdata,
   output logic                       unit_in_reset,
   output logic                       data_phase,
   output logic [NUM_REGS*DATA_W-1:0] reg_image
);

   if (NUM_REGS < 2 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_regs
      $error("ira_port: NUM_REGS must lie in 2 .. 2**ADDR_W");
   end
   if (DATA_W < ADDR_W) begin : g_bad_width
      $error("ira_port: DATA_W must hold a full pointer");
   end
   if (RST_BIT < 0 || RST_BIT >= DATA_W) begin : g_bad_bit
      $error("ira_port: RST_BIT outside the data byte");
   end

   ira_phase_e        phase;
   logic [ADDR_W-1:0] ptr;
   logic              we;
   logic [ADDR_W-1:0] waddr;
   logic              rsel;
   logic              in_rst;
   logic [DATA_W-1:0] rf_rdata;

   ira_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (host_wr),
      .rd       (host_rd),
      .wdata    (host_wdata),
      .in_reset (in_rst),
      .phase_o  (phase),
      .ptr_o    (ptr),
      .we_o     (we),
      .waddr_o  (waddr),
      .rsel_o   (rsel)
   );

   ira_regfile #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .RST_BIT(RST_BIT)
   ) i_regfile (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (we),
      .waddr    (waddr),
      .wdata    (host_wdata),
      .raddr    (ptr),
      .rdata    (rf_rdata),
      .in_reset (in_rst),
      .image    (reg_image)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         host_rdata <= '0;
      else if (host_rd && !host_wr)
         host_rdata <= rsel ? rf_rdata : '0;
   end

   assign unit_in_reset = in_rst;
   assign data_phase    = (phase == PH_DATA);

endmodule

// File: rtl/ira_port_chk.sv
module ira_port_chk #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 16,
   parameter int RST_BIT  = 0
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       host_wr,
   input logic                       host_rd,
   input logic [DATA_W-1:0]          host_wdata,
   input logic [DATA_W-1:0]          host_rdata,
   input logic                       unit_in_reset,
   input logic                       data_phase,
   input logic [NUM_REGS*DATA_W-1:0] reg_image
);

   localparam logic [DATA_W-1:0] RST_ONE = {{(DATA_W-1){1'b0}}, 1'b1} << RST_BIT;

   assert_ptr_to_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!unit_in_reset && !data_phase && host_wr) |=> data_phase);

   assert_data_wr_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_phase && host_wr) |=> !data_phase);

   assert_data_rd_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_phase && host_rd && !host_wr) |=> (!data_phase && $stable(reg_image)));

   assert_ptr_rd_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!unit_in_reset && !data_phase && host_rd && !host_wr)
      |=> (!data_phase && host_rdata == '0 && $stable(reg_image)));

   assert_enter_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unit_in_reset) |-> (!data_phase && reg_image[DATA_W-1:0] == RST_ONE
                                && reg_image[NUM_REGS*DATA_W-1:DATA_W] == '0));

   assert_reset_ptr_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
      unit_in_reset |-> !data_phase);

   assert_reset_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_in_reset && host_rd && !host_wr)
      |=> ($stable(reg_image) && !data_phase && host_rdata == '0));

   assert_both_strobes_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_rd) |=> $stable(host_rdata));

   assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_rd && !host_wr) |=> $stable(host_rdata));

endmodule

bind ira_port ira_port_chk #(
   .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .RST_BIT(RST_BIT)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .host_wr       (host_wr),
   .host_rd       (host_rd),
   .host_wdata    (host_wdata),
   .host_rdata    (host_rdata),
   .unit_in_reset (unit_in_reset),
   .data_phase    (data_phase),
   .reg_image     (reg_image)
);

// File: tb/test_ira_port.sv
module test_ira_port;
   localparam int CLK_PERIOD = 10;
   localparam int DW   = 8;
   localparam int AW   = 6;
   localparam int NR   = 16;
   localparam int IMGW = NR * DW;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            host_wr = 1'b0;
   logic            host_rd = 1'b0;
   logic [DW-1:0]   host_wdata = '0;
   logic [DW-1:0]   host_rdata;
   logic            unit_in_reset;
   logic            data_phase;
   logic [IMGW-1:0] reg_image;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [DW-1:0] m_reg [NR];
   logic          m_phase;
   logic [AW-1:0] m_ptr;
   logic [DW-1:0] m_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   ira_port #(.DATA_W(DW), .ADDR_W(AW), .NUM_REGS(NR)) i_ira_port (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .unit_in_reset(unit_in_reset), .data_phase(data_phase), .reg_image(reg_image)
   );

   task automatic chk(input bit ok, input string tag, input logic [IMGW-1:0] act,
                      input logic [IMGW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [IMGW-1:0] m_image();
      logic [IMGW-1:0] img;
      for (int i = 0; i < NR; i++) img[i*DW +: DW] = m_reg[i];
      return img;
   endfunction

   function automatic void m_clear_all(input logic keep_rst);
      for (int i = 0; i < NR; i++) m_reg[i] = '0;
      m_reg[0][0] = keep_rst;
   endfunction

   function automatic void m_write(input logic [DW-1:0] v);
      if (m_reg[0][0]) begin
         m_reg[0] = {{(DW-1){1'b0}}, v[0]};
         m_phase = 1'b0;
      end else if (!m_phase) begin
         m_ptr = v[AW-1:0];
         m_phase = 1'b1;
      end else begin
         if (m_ptr == 0 && v[0]) m_clear_all(1'b1);
         else if (int'(m_ptr) < NR) m_reg[m_ptr] = v;
         m_phase = 1'b0;
      end
   endfunction

   function automatic void m_read();
      if (m_reg[0][0] || !m_phase) m_rdata = '0;
      else m_rdata = (int'(m_ptr) < NR) ? m_reg[m_ptr] : '0;
      m_phase = 1'b0;
   endfunction

   task automatic check_state(input string tag);
      chk(data_phase == m_phase, {tag, " phase"}, IMGW'(data_phase), IMGW'(m_phase));
      chk(unit_in_reset == m_reg[0][0], {tag, " in_reset"}, IMGW'(unit_in_reset),
          IMGW'(m_reg[0][0]));
      chk(reg_image == m_image(), {tag, " image"}, reg_image, m_image());
   endtask

   task automatic op_wr(input logic [DW-1:0] v);
      @(negedge clk);
      host_wr = 1'b1; host_wdata = v;
      @(negedge clk);
      host_wr = 1'b0;
      m_write(v);
   endtask

   task automatic op_rd(input string tag);
      @(negedge clk);
      host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      m_read();
      chk(host_rdata == m_rdata, {tag, " rdata"}, IMGW'(host_rdata), IMGW'(m_rdata));
   endtask

   task automatic op_both(input logic [DW-1:0] v);
      @(negedge clk);
      host_wr = 1'b1; host_rd = 1'b1; host_wdata = v;
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0;
      m_write(v);
   endtask

   task automatic recover_seq();
      op_rd("R10 seq");
      op_wr(8'h00);
      op_rd("R10 seq");
      op_wr(8'h00);
      op_wr(8'h01);
      op_wr(8'h00);
      chk(!data_phase && !unit_in_reset && reg_image == '0, "R10 recovery",
          {reg_image, data_phase, unit_in_reset}, '0);
   endtask

   initial begin
      logic [DW-1:0] held;
      m_clear_all(1'b1);
      m_phase = 1'b0; m_ptr = '0; m_rdata = '0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: state right after reset
      chk(unit_in_reset == 1'b1, "R1 in_reset", IMGW'(unit_in_reset), 1);
      chk(data_phase == 1'b0, "R1 phase", IMGW'(data_phase), 0);
      chk(host_rdata == '0, "R1 rdata", IMGW'(host_rdata), 0);
      chk(reg_image == IMGW'(1), "R1 image", reg_image, IMGW'(1));

      // R8: release from reset
      op_wr(8'h00);
      chk(unit_in_reset == 1'b0, "R8 release", IMGW'(unit_in_reset), 0);
      check_state("R8");

      // R5: read in pointer phase
      op_rd("R5");
      check_state("R5");

      // R2/R3: pointer with upper bits set, then data
      op_wr(8'h45);
      chk(data_phase == 1'b1, "R2 to data phase", IMGW'(data_phase), 1);
      check_state("R2");
      op_wr(8'hA7);
      chk(reg_image[5*DW +: DW] == 8'hA7, "R3 reg5", IMGW'(reg_image[5*DW +: DW]), 8'hA7);
      check_state("R3");

      // R4: read back
      op_wr(8'h05);
      op_rd("R4");
      chk(host_rdata == 8'hA7, "R4 value", IMGW'(host_rdata), 8'hA7);
      check_state("R4");

      // R12: hold across idle cycles
      repeat (4) @(negedge clk);
      chk(host_rdata == 8'hA7, "R12 hold", IMGW'(host_rdata), 8'hA7);

      // R6: pointer beyond implemented range
      op_wr(8'h28);
      op_wr(8'h5A);
      check_state("R6 write ignored");
      op_wr(8'h28);
      op_rd("R6 read zero");

      // R11: both strobes act as a write only
      op_wr(8'h05);
      op_rd("R11 setup");
      held = host_rdata;
      op_both(8'h03);
      chk(host_rdata == held, "R11 rdata kept", IMGW'(host_rdata), IMGW'(held));
      chk(data_phase == 1'b1, "R11 acted as pointer write", IMGW'(data_phase), 1);
      op_wr(8'h33);
      check_state("R11");

      // R7: enter reset with upper bits also set
      op_wr(8'h00);
      op_wr(8'h81);
      chk(reg_image == IMGW'(1), "R7 image", reg_image, IMGW'(1));
      check_state("R7");

      // R9: read in reset
      op_rd("R9");
      check_state("R9");

      // R8: odd write stays, even write releases
      op_wr(8'hFF);
      chk(reg_image == IMGW'(1), "R8 stay", reg_image, IMGW'(1));
      op_wr(8'hFE);
      chk(reg_image == '0 && !unit_in_reset, "R8 release even", reg_image, '0);
      check_state("R8");

      // R10: recovery from pointer phase, data phase, reset
      op_wr(8'h07); op_wr(8'h11);
      recover_seq();
      m_clear_all(1'b0); m_phase = 1'b0;
      op_wr(8'h02); op_wr(8'h22); op_wr(8'h02);
      chk(data_phase == 1'b1, "R10 data start", IMGW'(data_phase), 1);
      recover_seq();
      m_clear_all(1'b0); m_phase = 1'b0;
      op_wr(8'h00); op_wr(8'h01);
      chk(unit_in_reset == 1'b1, "R10 reset start", IMGW'(unit_in_reset), 1);
      recover_seq();
      m_clear_all(1'b0); m_phase = 1'b0;

      // Random mix against the model (R2 R3 R4 R7 R8)
      for (int k = 0; k < 400; k++) begin
         int sel;
         logic [DW-1:0] v;
         sel = $urandom_range(0, 9);
         v = DW'($urandom);
         if (!m_phase && !m_reg[0][0]) begin
            if ($urandom_range(0, 7) == 0) v[AW-1:0] = '0;
            else if ($urandom_range(0, 3) != 0) v[AW-1:0] = AW'($urandom_range(1, NR-1));
         end
         if (m_phase && m_ptr == 0 && $urandom_range(0, 3) != 0) v[0] = 1'b0;
         if (sel < 6) op_wr(v);
         else if (sel < 9) op_rd("R4 random");
         else op_both(v);
         check_state("R3 random");
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule